// File: doc/BRIEF.md
# Packed Six-Bit Character String Mover

This engine copies or compares runs of 6-bit characters held ten to a 60-bit word in a word-addressed memory. A command names a source word and starting slot, a destination word and starting slot, a character count and an operation. The source and destination slots need not match. The engine realigns characters across word boundaries. It writes each destination word back only after reading it, so characters outside the target run keep their values.

Work proceeds one character per cycle in state `S_STEP`, with word fetches between steps. From `S_IDLE` an accepted command goes to `S_DONE` when its effective length is zero, and to `S_SRD` otherwise. `S_SRD` (source read request) leads to `S_SCAP` (capture the source word). `S_SCAP` leads to `S_DRD` when a fresh destination word is needed, and to `S_STEP` otherwise. `S_DRD` (destination read request) leads to `S_DCAP` (capture), and `S_DCAP` leads to `S_STEP`. From `S_STEP` the engine goes to:
- `S_DONE` on a compare mismatch, or on the last character of a compare;
- `S_DWR` on the last character of a move, or when the destination slot wraps during a move;
- `S_SRD` or `S_DRD` when the destination slot wraps during a compare;
- `S_SRD` when only the source slot wraps;
- `S_STEP` again in every other case.

`S_DWR` writes the destination word. It then goes to `S_DONE` when no characters remain, and to `S_SRD` or `S_DRD` otherwise. `S_DONE` pulses `done` and returns to `S_IDLE`.

Top module: `char_mover`

## Requirements
- R1: Character slot 1 of a word occupies bits 59:54 and slot 10 occupies bits 5:0. Position inputs take values 1 to 10.
- R2: A move copies the characters in order, from the source run to the destination run, for any pair of starting slots, across as many word boundaries as the run spans.
- R3: Destination characters before and after the run, in its first and last words, keep their values. No word outside the destination run is written.
- R4: The short move (op code 0) takes its length from `cmd_len[6:0]` only, so it moves at most 127 characters, and the upper length bits have no effect.
- R5: The long move (op code 1) uses all 13 length bits, up to 8191 characters.
- R6: A compare (op code 2) never writes memory.
- R7: A compare stops at the first unequal character pair. It reports `cmp_rel` = 1 when the source code is smaller (unsigned) and 2 when it is larger. `cmp_off` gives the 0-based index of that pair.
- R8: A compare of equal strings reports `cmp_rel` = 0 and `cmp_off` equal to the length.
- R9: A zero effective length raises `done` in the cycle after acceptance, with no memory request, and reports `cmp_rel` = 0 and `cmp_off` = 0.
- R10: `cmd_ready` is high only while idle, and a command is accepted when `cmd_valid` and `cmd_ready` are both high. `done` is a one-cycle pulse. Result outputs hold until the next command is accepted, and a move leaves them at 0.
- R11: After reset, `cmd_ready` = 1, `done` = 0, `mem_req` = 0, `cmp_rel` = 0 and `cmp_off` = 0.
- R12: Read data returned by the memory is taken one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cmd_valid | input | 1 | command present |
| cmd_ready | output | 1 | engine idle, command can be taken |
| cmd_op | input | 2 | 0 short move, 1 long move, 2 compare |
| cmd_src_addr | input | 18 | source word address |
| cmd_src_pos | input | 4 | source starting slot, 1..10 |
| cmd_dst_addr | input | 18 | destination word address |
| cmd_dst_pos | input | 4 | destination starting slot, 1..10 |
| cmd_len | input | 13 | character count |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | write when high, read when low |
| mem_addr | output | 18 | memory word address |
| mem_wdata | output | 60 | write data |
| mem_rdata | input | 60 | read data, one cycle after request |
| done | output | 1 | command finished pulse |
| cmp_rel | output | 2 | compare relation: 0 equal, 1 less, 2 greater |
| cmp_off | output | 13 | mismatch index, or length when equal |

## Verification
The hardest cases to reach are those where the source slot and the destination slot wrap on the same step, and where the last character lands exactly on slot 10. The stimulus reaches both from the ports by choosing starting slots and lengths. It runs a 72-character move from slot 3 to slot 9, an aligned single-word move, and a 1000-character long move from slot 7 to slot 2. The bench model then holds the whole memory image fixed and compares every word, which also catches a stray write into a neighbour. For compare, the bench first copies a run with a move, then alters one source character directly in memory, so the mismatch offset and direction are known in advance.

// File: rtl/mover_pkg.sv
package mover_pkg;
    typedef enum logic [1:0] {
        OP_SHORT = 2'd0,
        OP_LONG  = 2'd1,
        OP_CMP   = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2
    } rel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SRD,
        S_SCAP,
        S_DRD,
        S_DCAP,
        S_STEP,
        S_DWR,
        S_DONE
    } state_e;
endpackage

// File: rtl/chr_pick.sv
module chr_pick #(
    parameter int CHAR_W = 6,
    parameter int SLOTS  = 10,
    parameter int POS_W  = 4
) (
    input  logic [CHAR_W*SLOTS-1:0] word,
    input  logic [POS_W-1:0]        slot,
    output logic [CHAR_W-1:0]       ch
);
    logic [CHAR_W-1:0] lane [SLOTS];

    // slot 0 is the most significant character
    for (genvar g = 0; g < SLOTS; g++) begin : g_lane
        assign lane[g] = word[(SLOTS-g)*CHAR_W-1 -: CHAR_W];
    end

    always_comb begin
        ch = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (slot == POS_W'(i)) ch = lane[i];
        end
    end
endmodule

// File: rtl/chr_place.sv
module chr_place #(
    parameter int CHAR_W = 6,
    parameter int SLOTS  = 10,
    parameter int POS_W  = 4
) (
    input  logic [CHAR_W*SLOTS-1:0] word_in,
    input  logic [POS_W-1:0]        slot,
    input  logic [CHAR_W-1:0]       ch,
    output logic [CHAR_W*SLOTS-1:0] word_out
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_lane
        assign word_out[(SLOTS-g)*CHAR_W-1 -: CHAR_W] =
            (slot == POS_W'(g)) ? ch : word_in[(SLOTS-g)*CHAR_W-1 -: CHAR_W];
    end
endmodule

// File: rtl/char_mover.sv
module char_mover
    import mover_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int CHAR_W  = 6,
    parameter int SLOTS   = 10,
    parameter int LEN_W   = 13,
    parameter int SHORT_W = 7,
    localparam int WORD_W = CHAR_W * SLOTS,
    localparam int POS_W  = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_src_addr,
    input  logic [POS_W-1:0]  cmd_src_pos,
    input  logic [ADDR_W-1:0] cmd_dst_addr,
    input  logic [POS_W-1:0]  cmd_dst_pos,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [1:0]        cmp_rel,
    output logic [LEN_W-1:0]  cmp_off
);
    localparam logic [POS_W-1:0] LAST_SLOT = POS_W'(SLOTS - 1);

    state_e             state, nxt;
    op_e                op_q;
    logic [ADDR_W-1:0]  saddr_q, daddr_q;
    logic [POS_W-1:0]   sslot_q, dslot_q;
    logic [LEN_W-1:0]   left_q, cnt_q, len_q, off_q;
    logic [WORD_W-1:0]  sword_q, dword_q, merged;
    logic               need_dst_q, need_src_q;
    rel_e               rel_q;

    logic [CHAR_W-1:0]  sc, dc;
    logic [LEN_W-1:0]   eff_len;
    logic               is_cmp, swrap, dwrap, mism, last;

    chr_pick #(.CHAR_W(CHAR_W), .SLOTS(SLOTS), .POS_W(POS_W)) u_psrc (
        .word(sword_q), .slot(sslot_q), .ch(sc));
    chr_pick #(.CHAR_W(CHAR_W), .SLOTS(SLOTS), .POS_W(POS_W)) u_pdst (
        .word(dword_q), .slot(dslot_q), .ch(dc));
    chr_place #(.CHAR_W(CHAR_W), .SLOTS(SLOTS), .POS_W(POS_W)) u_put (
        .word_in(dword_q), .slot(dslot_q), .ch(sc), .word_out(merged));

    assign eff_len = (op_e'(cmd_op) == OP_SHORT) ?
                     LEN_W'(cmd_len[SHORT_W-1:0]) : cmd_len;
    assign is_cmp  = (op_q == OP_CMP);
    assign swrap   = (sslot_q == LAST_SLOT);
    assign dwrap   = (dslot_q == LAST_SLOT);
    assign mism    = is_cmp && (sc != dc);
    assign last    = (left_q == LEN_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (cmd_valid) nxt = (eff_len == '0) ? S_DONE : S_SRD;
            S_SRD:  nxt = S_SCAP;
            S_SCAP: nxt = need_dst_q ? S_DRD : S_STEP;
            S_DRD:  nxt = S_DCAP;
            S_DCAP: nxt = S_STEP;
            S_STEP: begin
                if (mism)          nxt = S_DONE;
                else if (last)     nxt = is_cmp ? S_DONE : S_DWR;
                else if (dwrap)    nxt = is_cmp ? (swrap ? S_SRD : S_DRD) : S_DWR;
                else if (swrap)    nxt = S_SRD;
                else               nxt = S_STEP;
            end
            S_DWR:  nxt = (left_q == '0) ? S_DONE : (need_src_q ? S_SRD : S_DRD);
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = (state == S_IDLE);
        done      = (state == S_DONE);
        mem_req   = (state == S_SRD) || (state == S_DRD) || (state == S_DWR);
        mem_we    = (state == S_DWR);
        mem_addr  = (state == S_SRD) ? saddr_q : daddr_q;
        mem_wdata = dword_q;
        cmp_rel   = rel_q;
        cmp_off   = off_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_SHORT;
            saddr_q    <= '0;
            daddr_q    <= '0;
            sslot_q    <= '0;
            dslot_q    <= '0;
            left_q     <= '0;
            cnt_q      <= '0;
            len_q      <= '0;
            off_q      <= '0;
            sword_q    <= '0;
            dword_q    <= '0;
            need_dst_q <= 1'b0;
            need_src_q <= 1'b0;
            rel_q      <= REL_EQ;
        end else begin
            case (state)
                S_IDLE: if (cmd_valid) begin
                    op_q       <= op_e'(cmd_op);
                    saddr_q    <= cmd_src_addr;
                    daddr_q    <= cmd_dst_addr;
                    sslot_q    <= cmd_src_pos - 1'b1;
                    dslot_q    <= cmd_dst_pos - 1'b1;
                    left_q     <= eff_len;
                    len_q      <= eff_len;
                    cnt_q      <= '0;
                    need_dst_q <= 1'b1;
                    need_src_q <= 1'b0;
                    rel_q      <= REL_EQ;
                    off_q      <= '0;
                end
                S_SCAP: sword_q <= mem_rdata;
                S_DCAP: begin
                    dword_q    <= mem_rdata;
                    need_dst_q <= 1'b0;
                end
                S_STEP: begin
                    if (mism) begin
                        rel_q <= (sc < dc) ? REL_LT : REL_GT;
                        off_q <= cnt_q;
                    end else begin
                        if (!is_cmp) dword_q <= merged;
                        if (is_cmp && last) off_q <= cnt_q + 1'b1;
                        left_q  <= left_q - 1'b1;
                        cnt_q   <= cnt_q + 1'b1;
                        sslot_q <= swrap ? '0 : sslot_q + 1'b1;
                        dslot_q <= dwrap ? '0 : dslot_q + 1'b1;
                        if (swrap) saddr_q <= saddr_q + 1'b1;
                        if (dwrap) begin
                            need_dst_q <= 1'b1;
                            need_src_q <= swrap;
                            if (is_cmp) daddr_q <= daddr_q + 1'b1;
                        end
                    end
                end
                S_DWR: daddr_q <= daddr_q + 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mover_chk.sv
module mover_chk #(
    parameter int LEN_W   = 13,
    parameter int SHORT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [1:0]       cmd_op,
    input logic [LEN_W-1:0] cmd_len,
    input logic             mem_req,
    input logic             mem_we,
    input logic             done,
    input logic [1:0]       cmp_rel,
    input logic [LEN_W-1:0] cmp_off,
    input logic [1:0]       op_q,
    input logic [LEN_W-1:0] len_q
);
    logic             acc;
    logic [LEN_W-1:0] eff;
    assign acc = cmd_valid && cmd_ready;
    assign eff = (cmd_op == 2'd0) ? LEN_W'(cmd_len[SHORT_W-1:0]) : cmd_len;

    // R6
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == 2'd2 && !cmd_ready) |-> !(mem_req && mem_we));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cmd_ready);

    // R9
    zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && eff == '0) |=> (done && !mem_req));

    // R8
    equal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 2'd2 && cmp_rel == 2'd0) |-> (cmp_off == len_q));

    // R7
    mismatch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 2'd2 && cmp_rel != 2'd0) |-> (cmp_off < len_q));
endmodule

bind char_mover mover_chk #(.LEN_W(LEN_W), .SHORT_W(SHORT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .mem_req(mem_req), .mem_we(mem_we),
    .done(done), .cmp_rel(cmp_rel), .cmp_off(cmp_off),
    .op_q(op_q), .len_q(len_q));

// File: tb/sim_char_mover.sv
module sim_char_mover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [17:0] cmd_src_addr = '0, cmd_dst_addr = '0;
    logic [3:0]  cmd_src_pos = 4'd1, cmd_dst_pos = 4'd1;
    logic [12:0] cmd_len = '0;
    logic        mem_req, mem_we, done;
    logic [17:0] mem_addr;
    logic [59:0] mem_wdata;
    logic [59:0] mem_rdata = '0;
    logic [1:0]  cmp_rel;
    logic [12:0] cmp_off;

    int errors = 0, checks = 0;
    int req_cnt = 0, wr_cnt = 0, cyc = 0;
    logic [59:0] mem [512];
    logic [59:0] shadow [512];

    always #5 clk = ~clk;

    char_mover u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            req_cnt <= req_cnt + 1;
            if (mem_we) begin
                wr_cnt <= wr_cnt + 1;
                mem[mem_addr[8:0]] <= mem_wdata;
            end else begin
                mem_rdata <= mem[mem_addr[8:0]];
            end
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [5:0] getc(logic [59:0] w, int s);
        return w[59-6*s -: 6];
    endfunction

    function automatic logic [59:0] putc(logic [59:0] w, int s, logic [5:0] c);
        logic [59:0] r = w;
        r[59-6*s -: 6] = c;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_mem(input string req);
        int bad = -1;
        for (int i = 0; i < 512; i++)
            if (mem[i] !== shadow[i] && bad < 0) bad = i;
        if (bad >= 0) chk(1'b0, req, $sformatf("memory word %0d", bad), mem[bad], shadow[bad]);
        else chk(1'b1, req, "memory", 0, 0);
    endtask

    // R2 R3: bench model of a move, one character at a time
    task automatic ref_move(input int sa, sp, da, dp, len);
        for (int i = 0; i < len; i++) begin
            int si = sp - 1 + i;
            int di = dp - 1 + i;
            logic [5:0] c = getc(shadow[sa + si/10], si % 10);
            shadow[da + di/10] = putc(shadow[da + di/10], di % 10, c);
        end
    endtask

    // R7 R8: bench model of a compare
    task automatic ref_cmp(input int sa, sp, da, dp, len, output int rel, output int off);
        rel = 0; off = len;
        for (int i = 0; i < len; i++) begin
            int si = sp - 1 + i;
            int di = dp - 1 + i;
            logic [5:0] a = getc(shadow[sa + si/10], si % 10);
            logic [5:0] b = getc(shadow[da + di/10], di % 10);
            if (a != b) begin
                rel = (a < b) ? 1 : 2; off = i;
                break;
            end
        end
    endtask

    task automatic run(input int op, sa, sp, da, dp, len);
        int t = 0;
        @(negedge clk);
        req_cnt = 0; wr_cnt = 0;
        cmd_valid = 1'b1; cmd_op = 2'(op);
        cmd_src_addr = 18'(sa); cmd_src_pos = 4'(sp);
        cmd_dst_addr = 18'(da); cmd_dst_pos = 4'(dp);
        cmd_len = 13'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done === 1'b1, "R10", "done seen", done, 1);
    endtask

    task automatic t_reset();
        chk(cmd_ready === 1'b1, "R11", "cmd_ready", cmd_ready, 1);
        chk(done === 1'b0 && mem_req === 1'b0, "R11", "done/mem_req", {done, mem_req}, 0);
        chk(cmp_rel === 2'd0 && cmp_off === 13'd0, "R11", "results", {cmp_rel, cmp_off}, 0);
    endtask

    task automatic t_aligned();
        ref_move(5, 1, 40, 1, 10);
        run(1, 5, 1, 40, 1, 10);
        chk_mem("R1 R2");
        chk(cmp_rel === 2'd0 && cmp_off === 13'd0, "R10", "move results", {cmp_rel, cmp_off}, 0);
    endtask

    task automatic t_misaligned();
        ref_move(10, 3, 100, 9, 72);
        run(1, 10, 3, 100, 9, 72);
        chk_mem("R2 R3");
        @(negedge clk);
        chk(done === 1'b0, "R10", "done width", done, 0);
    endtask

    task automatic t_inword();
        ref_move(20, 8, 60, 2, 3);
        run(0, 20, 8, 60, 2, 3);
        chk_mem("R3");
        chk(wr_cnt == 1, "R3", "write count", wr_cnt, 1);
    endtask

    task automatic t_short_trunc();
        ref_move(30, 4, 70, 6, 5);
        run(0, 30, 4, 70, 6, 128 + 5);
        chk_mem("R4");
    endtask

    task automatic t_long();
        ref_move(200, 7, 320, 2, 1000);
        run(1, 200, 7, 320, 2, 1000);
        chk_mem("R5");
    endtask

    task automatic t_zero();
        run(2, 1, 1, 2, 1, 0);
        chk(req_cnt == 0, "R9", "memory requests", req_cnt, 0);
        chk(cmp_rel === 2'd0 && cmp_off === 13'd0, "R9", "results", {cmp_rel, cmp_off}, 0);
        run(0, 1, 1, 2, 1, 128);
        chk(req_cnt == 0, "R9 R4", "short len 128 requests", req_cnt, 0);
    endtask

    task automatic t_compare();
        int rel, off;
        ref_cmp(10, 3, 100, 9, 72, rel, off);
        run(2, 10, 3, 100, 9, 72);
        chk(cmp_rel === 2'(rel) && cmp_off === 13'(off), "R8", "equal", {cmp_rel, cmp_off}, {rel[1:0], off[12:0]});
        chk(wr_cnt == 0, "R6", "writes", wr_cnt, 0);
        repeat (3) @(negedge clk);
        chk(cmp_off === 13'(off), "R10", "result hold", cmp_off, off);
        // source char index 41 -> word 14, slot 3 (0-based); force smaller code
        mem[14] = putc(mem[14], 3, 6'd0);
        shadow[14] = mem[14];
        ref_cmp(10, 3, 100, 9, 72, rel, off);
        run(2, 10, 3, 100, 9, 72);
        chk(cmp_rel === 2'(rel) && cmp_off === 13'(off), "R7", "less", {cmp_rel, cmp_off}, {rel[1:0], off[12:0]});
        chk(off == 41 && rel == 1, "R7", "model less", off, 41);
        mem[12] = putc(mem[12], 0, 6'd63);
        shadow[12] = mem[12];
        ref_cmp(10, 3, 100, 9, 72, rel, off);
        run(2, 10, 3, 100, 9, 72);
        chk(cmp_rel === 2'(rel) && cmp_off === 13'(off), "R7", "greater", {cmp_rel, cmp_off}, {rel[1:0], off[12:0]});
        chk_mem("R6");
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 60'h0123456789ABCDE ^ (60'(i) * 60'h9E3779B97F4A7C1);
            // make slot 0 of word 12 nonzero-sized but below 63 for the greater case
            mem[i][59:54] = 6'(i % 60);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_aligned();
        t_misaligned();
        t_inword();
        t_short_trunc();
        t_zero();
        t_compare();
        t_long();
        // R12 is covered by every move: captured read data feeds the copies checked above
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule